// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external event happened, using a free-running counter that lives outside it. One of two trigger inputs is chosen: a general input pin or the output of an analog comparator. The chosen signal is resynchronised to the clock. An optional majority-free glitch filter can be switched in, and it passes a new level only once that level has been seen on several consecutive cycles. An edge detector then looks for a rising or falling transition, whichever is selected. When a qualifying transition arrives, the block copies the counter value into a capture register and sets a capture flag. When interrupts are enabled, the flag drives an interrupt request.

Software reaches the capture register through an 8-bit bus. A shared temporary byte keeps 16-bit accesses atomic. On reads, fetching the low byte freezes the high byte into the temporary byte, and a later high-byte read returns that frozen copy. On writes, software first loads the temporary byte through the high-byte address. The low-byte write then commits both halves in a single cycle. That commit only takes effect when the timer is in a mode that uses the capture register as its period limit. The flag clears on an interrupt acknowledge, or when software writes a one to it.

Top module: `icap_unit`

## Requirements
- R1: `src_sel`=0 selects `pin_in` and `src_sel`=1 selects `cmp_in`. Activity on the source that is not selected never sets the flag.
- R2: `edge_rise`=1 captures on a 0-to-1 transition and `edge_rise`=0 captures on a 1-to-0 transition. The opposite transition captures nothing.
- R3: With the filter off, a change applied to the source between clock edges is captured at the third rising edge after it. The value stored is the `count_in` value present at that edge.
- R4: `cap_flag` rises at the same clock edge that loads the capture register.
- R5: `irq` equals `cap_flag` AND `int_en`.
- R6: A one-cycle `irq_ack` clears `cap_flag`.
- R7: A bus write to address 2 with data bit 0 = 1 clears `cap_flag`. A write with bit 0 = 0 leaves it unchanged.
- R8: A read of address 0 returns bits 7:0 of the capture register and copies bits 15:8 into the temporary byte. A read of address 1 returns the temporary byte, even when a capture has happened since. A read of address 2 returns the flag in bit 0.
- R9: A write to address 1 loads the temporary byte. A write to address 0 while `top_mode`=1 stores {temporary byte, data}. A write to address 0 while `top_mode`=0 leaves the capture register unchanged.
- R10: With `filt_en`=1, a new level must be seen on four consecutive synchronised samples. This adds four cycles to the R3 latency, so the capture lands at the seventh edge. A pulse lasting three cycles is discarded.
- R11: When a capture and a write-one clear land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External event pin |
| cmp_in | input | 1 | Analog comparator output |
| src_sel | input | 1 | Trigger source select (1 = comparator) |
| filt_en | input | 1 | Glitch filter enable |
| edge_rise | input | 1 | 1 = rising edge, 0 = falling edge |
| int_en | input | 1 | Interrupt enable |
| top_mode | input | 1 | Timer mode uses the capture register as period limit |
| count_in | input | 16 | Free-running counter value |
| bus_addr | input | 2 | 0 = low byte, 1 = high byte / temp, 2 = flag |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational while `bus_rd` is high) |
| irq_ack | input | 1 | Interrupt acknowledge |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all eight combinations of source, edge polarity and filter. For each one it measures the exact edge at which the flag rises and the counter value that was stored. A design with an extra or missing pipeline stage would store the wrong count or raise the flag one cycle off, and a crossed source mux would capture from the idle input. Several other cases are also exercised:
- a capture that lands between a low-byte read and a high-byte read (a design without the frozen byte would return the new high byte);
- low-byte writes outside the period-limit mode, which must leave the register unchanged;
- a three-cycle glitch, which a filter that is too short would let through;
- a clear and a capture on the same edge, where a design that gives the clear priority would lose the event.

// File: rtl/icap_pkg.sv
package icap_pkg;
   typedef enum logic [1:0] {
      ADR_LO   = 2'd0,
      ADR_HI   = 2'd1,
      ADR_FLAG = 2'd2
   } icap_adr_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("icap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (LEN < 2) begin : g_bad_len
      $error("icap_filter: LEN must be at least 2");
   end

   logic [LEN-2:0] hist;
   logic           all_hi, all_lo;

   if (LEN == 2) begin : g_short
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist <= '0;
         else        hist <= d;
      end
   end else begin : g_long
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist <= '0;
         else        hist <= {hist[LEN-3:0], d};
      end
   end

   assign all_hi = &{hist, d};
   assign all_lo = ~|{hist, d};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (all_hi) q <= 1'b1;
      else if (all_lo) q <= 1'b0;
   end

   // R10: the filtered level only moves toward the newest sample
   a_r10_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> (q == $past(d)));
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   output logic evt
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign evt = rise_sel ? (lvl & ~prev) : (~lvl & prev);

   // R2: one input transition yields exactly one event cycle
   a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/icap_regs.sv
module icap_regs
   import icap_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic [CNT_W-1:0] count_in,
   input  logic             top_mode,
   input  logic             int_en,
   input  logic             ack,
   input  logic [1:0]       addr,
   input  logic             rd,
   input  logic             wr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             flag,
   output logic             irq
);
   localparam int HI_W = CNT_W - BUS_W;

   logic [CNT_W-1:0] cap;
   logic [HI_W-1:0]  temp;
   logic             rd_lo, wr_lo, wr_hi, clr_w1;

   assign rd_lo  = rd && (addr == ADR_LO);
   assign wr_lo  = wr && (addr == ADR_LO);
   assign wr_hi  = wr && (addr == ADR_HI);
   assign clr_w1 = wr && (addr == ADR_FLAG) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cap <= '0;
      else if (evt)              cap <= count_in;
      else if (wr_lo && top_mode) cap <= {temp, wdata};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     temp <= '0;
      else if (rd_lo) temp <= cap[CNT_W-1:BUS_W];
      else if (wr_hi) temp <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag <= 1'b0;
      else if (evt)            flag <= 1'b1;
      else if (ack || clr_w1)  flag <= 1'b0;
   end

   assign irq = flag & int_en;

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            ADR_LO:   rdata = cap[BUS_W-1:0];
            ADR_HI:   rdata = temp;
            ADR_FLAG: rdata[0] = flag;
            default:  rdata = '0;
         endcase
      end
   end

   // R3 / R4: register and flag load together from the counter
   a_r4_flag_with_load: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (flag && cap == $past(count_in)));
   // R6: acknowledge clears when no new event arrives
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !evt) |=> !flag);
   // R9: low-byte write outside period-limit mode changes nothing
   a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !top_mode && !evt) |=> $stable(cap));
   // R11: set beats write-one clear
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr_w1) |=> flag);
   // R8: temporary byte holds unless a low read or high write occurs
   a_r8_temp_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_lo && !wr_hi) |=> $stable(temp));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int BUS_W    = 8,
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             cmp_in,
   input  logic             src_sel,
   input  logic             filt_en,
   input  logic             edge_rise,
   input  logic             int_en,
   input  logic             top_mode,
   input  logic [CNT_W-1:0] count_in,
   input  logic [1:0]       bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             irq_ack,
   output logic             cap_flag,
   output logic             irq
);
   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("icap_unit: CNT_W must be twice BUS_W");
   end

   logic src_raw, src_sync, src_filt, lvl, evt;

   assign src_raw = src_sel ? cmp_in : pin_in;

   icap_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_raw), .q(src_sync));

   icap_filter #(.LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .d(src_sync), .q(src_filt));

   assign lvl = filt_en ? src_filt : src_sync;

   icap_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_sel(edge_rise), .evt(evt));

   icap_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .evt(evt), .count_in(count_in),
      .top_mode(top_mode), .int_en(int_en), .ack(irq_ack),
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
      .rdata(bus_rdata), .flag(cap_flag), .irq(irq));

   // R5: request only while enabled
   a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en) |-> !irq);
endmodule

// File: tb/icap_unit_test.sv
module icap_unit_test;
   localparam logic [15:0] STEP = 16'h0101;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        pin_in = 0, cmp_in = 0, src_sel = 0, filt_en = 0;
   logic        edge_rise = 1, int_en = 0, top_mode = 0, irq_ack = 0;
   logic [15:0] cnt = 16'h0000;
   logic [1:0]  bus_addr = 0;
   logic        bus_rd = 0, bus_wr = 0;
   logic [7:0]  bus_wdata = 0, bus_rdata;
   logic        cap_flag, irq;
   int          nchk = 0, nbad = 0;
   bit          done = 0;

   always #10 clk = ~clk;
   always @(negedge clk) cnt <= cnt + STEP;

   icap_unit uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
      .src_sel(src_sel), .filt_en(filt_en), .edge_rise(edge_rise),
      .int_en(int_en), .top_mode(top_mode), .count_in(cnt),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
      .cap_flag(cap_flag), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(2'd0, lo); rd(2'd1, hi);
      v = {hi, lo};
   endtask

   task automatic pulse_pin(input int n, output logic [15:0] c0);
      @(negedge clk); pin_in = 1; #1 c0 = cnt;
      repeat (n) @(negedge clk);
      pin_in = 0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      logic [15:0] v, c0, v1, v2;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("reset flag", cap_flag, 0);
      chk("reset irq R5", irq, 0);
      rd16(v); chk("reset register", v, 0);

      // sweep source x polarity x filter: R1 R2 R3 R4 R5 R6 R10
      for (int k = 0; k < 8; k++) begin
         logic s, r, f;
         int lat;
         s = k[0]; r = k[1]; f = k[2];
         @(negedge clk);
         src_sel = s; edge_rise = r; filt_en = f; int_en = k[0] ^ k[1];
         pin_in = ~r; cmp_in = ~r;
         repeat (12) @(negedge clk);
         wr(2'd2, 8'h01);
         @(negedge clk); if (s) pin_in = r; else cmp_in = r;
         repeat (12) @(negedge clk);
         chk("R1 unselected source ignored", cap_flag, 0);
         if (s) pin_in = ~r; else cmp_in = ~r;
         repeat (12) @(negedge clk);
         @(negedge clk); if (s) cmp_in = r; else pin_in = r;
         #1 c0 = cnt;
         lat = f ? 6 : 2;
         repeat (lat) @(negedge clk);
         chk(f ? "R10 flag not yet" : "R3 flag not yet", cap_flag, 0);
         @(negedge clk);
         chk("R4 flag at capture edge", cap_flag, 1);
         chk("R5 irq gating", irq, int_en);
         rd16(v);
         chk(f ? "R10 captured value" : "R3 captured value", v, c0 + 16'(lat) * STEP);
         @(negedge clk); irq_ack = 1;
         @(negedge clk); irq_ack = 0;
         chk("R6 ack clears", cap_flag, 0);
         if (s) cmp_in = ~r; else pin_in = ~r;
         repeat (12) @(negedge clk);
         chk("R2 opposite edge ignored", cap_flag, 0);
      end

      // fixed config: pin, rising, no filter
      @(negedge clk); src_sel = 0; edge_rise = 1; filt_en = 0; int_en = 1;
      pin_in = 0; repeat (12) @(negedge clk);
      pulse_pin(3, c0); repeat (8) @(negedge clk);
      v1 = c0 + 16'd2 * STEP;
      wr(2'd2, 8'h00); chk("R7 write zero keeps flag", cap_flag, 1);
      rd(2'd2, b);     chk("R8 flag readback", b, 8'h01);
      wr(2'd2, 8'h01); chk("R7 write one clears", cap_flag, 0);

      // R8: temp byte frozen across a later capture
      rd(2'd0, b); chk("R8 low byte", b, v1[7:0]);
      pulse_pin(3, c0); repeat (8) @(negedge clk);
      v2 = c0 + 16'd2 * STEP;
      rd(2'd1, b); chk("R8 stale high byte", b, v1[15:8]);
      rd16(v);     chk("R8 fresh pair", v, v2);

      // R9 writes
      top_mode = 0;
      wr(2'd1, 8'hAB); wr(2'd0, 8'hCD);
      rd16(v); chk("R9 write ignored", v, v2);
      top_mode = 1;
      wr(2'd1, 8'h5A); wr(2'd0, 8'hC3);
      rd16(v); chk("R9 paired write", v, 16'h5AC3);
      top_mode = 0;

      // R10 filter
      wr(2'd2, 8'h01);
      @(negedge clk); filt_en = 1;
      pulse_pin(3, c0); repeat (14) @(negedge clk);
      chk("R10 short pulse dropped", cap_flag, 0);
      pulse_pin(5, c0); repeat (14) @(negedge clk);
      chk("R10 long pulse accepted", cap_flag, 1);
      rd16(v); chk("R10 filtered value", v, c0 + 16'd6 * STEP);

      // R11 set vs clear on same edge
      @(negedge clk); filt_en = 0;
      repeat (12) @(negedge clk);
      wr(2'd2, 8'h01);
      @(negedge clk); pin_in = 1;
      repeat (2) @(negedge clk);
      bus_addr = 2'd2; bus_wdata = 8'h01; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
      chk("R11 set wins", cap_flag, 1);
      pin_in = 0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule